// File: doc/BRIEF.md
# Parallel Flash Command Decoder

This block is the device-side control logic of a byte-wide parallel flash model. The host drives chip-enable, output-enable and write-enable strobes, an address bus and a byte-wide data bus. All of these are sampled on the block clock. Write cycles carry command bytes. The decoder walks the device through its modes:

- reading the array;
- arming a program;
- running a timed program pulse;
- verifying a programmed byte;
- arming and running a whole-array erase;
- verifying erased bytes.

For each program operation the block latches an address and a data byte. A write to the device takes two write cycles. The first carries the command byte. The second carries the target address, captured as write-enable falls, and the data, captured as it rises. An internal stop timer ends each high-voltage pulse, so the host does not have to bound it. The same pulse also ends early if the host completes another write.

The storage is a behavioural byte array. A digital input stands in for the presence of the high programming voltage. Time is counted in clock cycles, using a cycles-per-microsecond parameter. After every pulse, a recovery window keeps the data outputs disabled until a read would be valid.

Top module: `flash_cmd_if`

## Requirements
- R1: After reset the output-enable flag is low, the block is in read mode, and every byte of the array reads FFh.
- R2: With chip-enable and output-enable low, write-enable high, and no pulse or recovery in progress, the output flag is high one clock later. The output byte then holds the array byte at the address on the bus in read mode.
- R3: Writing 40h arms a program. On the next write cycle, the address is taken from the bus in the cycle write-enable is seen falling. The data is taken in the cycle it is seen rising. The stored byte becomes the old value AND the new data, so programming only clears bits.
- R4: A program pulse lasts PROG_US*CYC_PER_US clock cycles and is then committed. The output flag stays low for the whole pulse.
- R5: A completed write cycle (rising write-enable) during a pulse ends the pulse at once and commits it. That write's byte is then decoded as a fresh command.
- R6: Writing C0h selects program-verify. Reads then return the byte at the latched program address, whatever is on the address bus.
- R7: Writing 20h twice runs an erase pulse of ERASE_US*CYC_PER_US cycles. At its end every byte of the array is FFh.
- R8: Writing A0h selects erase-verify. Reads then return the byte at the address that was on the bus in the cycle the A0h write completed.
- R9: After any pulse ends, the output flag stays low for a further RECOV_US*CYC_PER_US cycles.
- R10: While the high-voltage input is low, every write cycle leaves the block in read mode, and no program or erase starts.
- R11: A command byte other than 40h, C0h, 20h or A0h selects read mode. A second byte other than 20h after an erase arm also selects read mode, without erasing.
- R12: A falling write-enable during a program pulse does not alter the latched program address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all strobes are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| din | input | 8 | Command or program data byte |
| vpp_hi | input | 1 | High programming voltage present |
| dout | output | 8 | Read data byte |
| dout_oe | output | 1 | Read data valid / outputs driven |

## Verification
The bench builds the block with a 5-bit address, 2 cycles per microsecond, a 3 µs program pulse, a 5 µs erase pulse and a 2 µs recovery window. These values make a pulse 6 or 10 cycles long, so a second write cycle can land inside a running program pulse. They also make the recovery gap short enough to count exactly. The whole 32-byte array can then be read back after an erase. A behavioural model predicts the output flag and the read byte on every clock. Directed sequences cover:
- bit-clearing reprogramming;
- early termination;
- both verify modes;
- commands ignored with the voltage absent;
- aborted erase arming.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

    typedef logic [7:0] cmd_byte_t;

    localparam cmd_byte_t CMD_PROG_ARM    = 8'h40;
    localparam cmd_byte_t CMD_PROG_CHECK  = 8'hC0;
    localparam cmd_byte_t CMD_ERASE_ARM   = 8'h20;
    localparam cmd_byte_t CMD_ERASE_CHECK = 8'hA0;

    typedef enum logic [2:0] {
        MODE_READ     = 3'd0,
        MODE_PARM     = 3'd1,
        MODE_PROG     = 3'd2,
        MODE_PCHECK   = 3'd3,
        MODE_EARM     = 3'd4,
        MODE_ERASE    = 3'd5,
        MODE_ECHECK   = 3'd6
    } mode_e;

    // Mode selected by a command byte written outside the arm states.
    function automatic mode_e decode_cmd(input cmd_byte_t b);
        case (b)
            CMD_PROG_ARM:    return MODE_PARM;
            CMD_PROG_CHECK:  return MODE_PCHECK;
            CMD_ERASE_ARM:   return MODE_EARM;
            CMD_ERASE_CHECK: return MODE_ECHECK;
            default:         return MODE_READ;
        endcase
    endfunction

endpackage

// File: rtl/flash_strobe_edge.sv
module flash_strobe_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic ce_n,
    input  logic we_n,
    output logic we_fall,
    output logic we_rise
);

    logic we_prev_d, we_prev_q;

    always_comb begin
        we_prev_d = we_n;
        we_fall   = !ce_n && we_prev_q && !we_n;
        we_rise   = !ce_n && !we_prev_q && we_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            we_prev_q <= 1'b1;
        end else begin
            we_prev_q <= we_prev_d;
        end
    end

endmodule

// File: rtl/flash_stop_timer.sv
module flash_stop_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clear,
    input  logic [W-1:0] len,
    output logic [W-1:0] remain
);

    logic [W-1:0] remain_d, remain_q;

    always_comb begin
        if (load) begin
            remain_d = len;
        end else if (clear) begin
            remain_d = '0;
        end else if (remain_q != '0) begin
            remain_d = remain_q - W'(1);
        end else begin
            remain_d = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else begin
            remain_q <= remain_d;
        end
    end

    assign remain = remain_q;

endmodule

// File: rtl/flash_byte_array.sv
module flash_byte_array #(
    parameter int AW = 10,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          prog_en,
    input  logic [AW-1:0] prog_addr,
    input  logic [DW-1:0] prog_data,
    input  logic          erase_en,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells_q [DEPTH];

    // Erase restores every cell to all ones; programming can only clear bits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '1;
            end
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++) begin
                cells_q[i] <= '1;
            end
        end else if (prog_en) begin
            cells_q[prog_addr] <= cells_q[prog_addr] & prog_data;
        end
    end

    assign rd_data = cells_q[rd_addr];

endmodule

// File: rtl/flash_cmd_if.sv
module flash_cmd_if #(
    parameter int ADDR_W     = 10,
    parameter int CYC_PER_US = 100,
    parameter int PROG_US    = 10,
    parameter int ERASE_US   = 10000,
    parameter int RECOV_US   = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        din,
    input  logic              vpp_hi,
    output logic [7:0]        dout,
    output logic              dout_oe
);

    import flash_cmd_pkg::*;

    localparam int PROG_CYC  = PROG_US * CYC_PER_US;
    localparam int ERASE_CYC = ERASE_US * CYC_PER_US;
    localparam int RECOV_CYC = RECOV_US * CYC_PER_US;
    localparam int PULSE_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
    localparam int PT_W      = $clog2(PULSE_MAX + 1);
    localparam int RT_W      = $clog2(RECOV_CYC + 2);

    typedef struct packed {
        mode_e             mode;
        logic [ADDR_W-1:0] addr;
        logic [7:0]        data;
        logic [7:0]        dout;
        logic              dout_oe;
    } ctl_t;

    ctl_t st_d, st_q;

    logic            we_fall, we_rise;
    logic [PT_W-1:0] pulse_remain;
    logic [RT_W-1:0] recov_remain;
    logic [PT_W-1:0] pulse_len;
    logic            pulse_start, pulse_is_erase;
    logic            busy, pulse_last, pulse_end;
    logic            prog_commit, erase_commit;
    logic            recov_active;
    logic [ADDR_W-1:0] rd_addr;
    logic [7:0]      rd_data;
    mode_e           mode_q;
    logic [ADDR_W-1:0] addr_q;

    assign mode_q = st_q.mode;
    assign addr_q = st_q.addr;

    flash_strobe_edge u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n    (ce_n),
        .we_n    (we_n),
        .we_fall (we_fall),
        .we_rise (we_rise)
    );

    flash_stop_timer #(.W(PT_W)) u_pulse (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (pulse_start),
        .clear  (pulse_end),
        .len    (pulse_len),
        .remain (pulse_remain)
    );

    flash_stop_timer #(.W(RT_W)) u_recov (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (pulse_end),
        .clear  (1'b0),
        .len    (RT_W'(RECOV_CYC)),
        .remain (recov_remain)
    );

    flash_byte_array #(.AW(ADDR_W), .DW(8)) u_array (
        .clk       (clk),
        .rst_n     (rst_n),
        .prog_en   (prog_commit),
        .prog_addr (st_q.addr),
        .prog_data (st_q.data),
        .erase_en  (erase_commit),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    always_comb begin
        busy         = (st_q.mode == MODE_PROG) || (st_q.mode == MODE_ERASE);
        pulse_last   = (pulse_remain == PT_W'(1));
        pulse_end    = busy && (pulse_last || we_rise);
        prog_commit  = pulse_end && (st_q.mode == MODE_PROG);
        erase_commit = pulse_end && (st_q.mode == MODE_ERASE);
        recov_active = (recov_remain != '0);
        rd_addr      = ((st_q.mode == MODE_PCHECK) || (st_q.mode == MODE_ECHECK))
                     ? st_q.addr : addr;
        pulse_len    = pulse_is_erase ? PT_W'(ERASE_CYC) : PT_W'(PROG_CYC);
    end

    always_comb begin
        st_d           = st_q;
        pulse_start    = 1'b0;
        pulse_is_erase = 1'b0;

        st_d.dout    = rd_data;
        st_d.dout_oe = !ce_n && !oe_n && we_n && !busy && !recov_active;

        unique case (st_q.mode)
            MODE_PARM: begin
                if (we_fall) begin
                    st_d.addr = addr;
                end
                if (we_rise) begin
                    if (vpp_hi) begin
                        st_d.data   = din;
                        st_d.mode   = MODE_PROG;
                        pulse_start = 1'b1;
                    end else begin
                        st_d.mode = MODE_READ;
                    end
                end
            end
            MODE_EARM: begin
                if (we_rise) begin
                    if (vpp_hi && (din == CMD_ERASE_ARM)) begin
                        st_d.mode      = MODE_ERASE;
                        pulse_start    = 1'b1;
                        pulse_is_erase = 1'b1;
                    end else begin
                        st_d.mode = MODE_READ;
                    end
                end
            end
            MODE_PROG, MODE_ERASE: begin
                if (pulse_end) begin
                    st_d.mode = MODE_READ;
                    if (we_rise && vpp_hi) begin
                        st_d.mode = decode_cmd(din);
                        if (st_d.mode == MODE_ECHECK) begin
                            st_d.addr = addr;
                        end
                    end
                end
            end
            default: begin
                if (we_rise) begin
                    if (vpp_hi) begin
                        st_d.mode = decode_cmd(din);
                        if (st_d.mode == MODE_ECHECK) begin
                            st_d.addr = addr;
                        end
                    end else begin
                        st_d.mode = MODE_READ;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= MODE_READ;
            st_q.addr    <= '0;
            st_q.data    <= '1;
            st_q.dout    <= '0;
            st_q.dout_oe <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout    = st_q.dout;
    assign dout_oe = st_q.dout_oe;

endmodule

// File: rtl/flash_cmd_if_chk.sv
module flash_cmd_if_chk #(
    parameter int AW = 10
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 ce_n,
    input logic                 oe_n,
    input logic                 we_n,
    input logic                 vpp_hi,
    input logic [7:0]           din,
    input logic                 dout_oe,
    input logic                 we_rise,
    input logic                 pulse_last,
    input logic                 recov_active,
    input flash_cmd_pkg::mode_e mode_q,
    input logic [AW-1:0]        addr_q
);

    import flash_cmd_pkg::*;

    logic known_cmd;
    assign known_cmd = (din == CMD_PROG_ARM) || (din == CMD_PROG_CHECK) ||
                       (din == CMD_ERASE_ARM) || (din == CMD_ERASE_CHECK);

    a_r2_oe_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
        dout_oe |-> $past(!ce_n && !oe_n && we_n));

    a_r4_oe_low_in_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROG || mode_q == MODE_ERASE) |=> !dout_oe);

    a_r4_pulse_stops: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROG && pulse_last) |=> (mode_q != MODE_PROG));

    a_r3_arm_to_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PARM && we_rise && vpp_hi) |=> (mode_q == MODE_PROG));

    a_r9_oe_low_in_recovery: assert property (@(posedge clk) disable iff (!rst_n)
        recov_active |=> !dout_oe);

    a_r10_no_vpp_read: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise && !vpp_hi) |=> (mode_q == MODE_READ));

    a_r11_unknown_read: assert property (@(posedge clk) disable iff (!rst_n)
        (we_rise && vpp_hi && mode_q == MODE_READ && !known_cmd) |=> (mode_q == MODE_READ));

    a_r12_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_PROG && !we_rise) |=> $stable(addr_q));

    a_r7_erase_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == MODE_ERASE && $past(mode_q) != MODE_ERASE) |-> ($past(mode_q) == MODE_EARM));

endmodule

bind flash_cmd_if flash_cmd_if_chk #(.AW(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ce_n         (ce_n),
    .oe_n         (oe_n),
    .we_n         (we_n),
    .vpp_hi       (vpp_hi),
    .din          (din),
    .dout_oe      (dout_oe),
    .we_rise      (we_rise),
    .pulse_last   (pulse_last),
    .recov_active (recov_active),
    .mode_q       (mode_q),
    .addr_q       (addr_q)
);

// File: tb/test_flash_cmd_if.sv
module test_flash_cmd_if;

    localparam int AW    = 5;
    localparam int CPU   = 2;
    localparam int PUS   = 3;
    localparam int EUS   = 5;
    localparam int RUS   = 2;
    localparam int NPROG = PUS * CPU;
    localparam int NERA  = EUS * CPU;
    localparam int NREC  = RUS * CPU;
    localparam int DEPTH = 1 << AW;

    localparam int M_READ = 0, M_PARM = 1, M_PROG = 2, M_PCHK = 3,
                   M_EARM = 4, M_ERASE = 5, M_ECHK = 6;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [7:0]    din = '0;
    logic          vpp_hi = 1'b1;
    logic [7:0]    dout;
    logic          dout_oe;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    flash_cmd_if #(
        .ADDR_W(AW), .CYC_PER_US(CPU), .PROG_US(PUS),
        .ERASE_US(EUS), .RECOV_US(RUS)
    ) i_flash_cmd_if (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .vpp_hi(vpp_hi), .dout(dout), .dout_oe(dout_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    int   m_mode, m_addr, m_pulse, m_recov;
    logic [7:0] m_data, m_dout;
    logic m_oe, m_weprev;
    logic [7:0] m_mem [DEPTH];

    task automatic m_cmd(input int idx);
        case (din)
            8'h40: m_mode = M_PARM;
            8'hC0: m_mode = M_PCHK;
            8'h20: m_mode = M_EARM;
            8'hA0: begin m_mode = M_ECHK; m_addr = idx; end
            default: m_mode = M_READ;
        endcase
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = M_READ; m_addr = 0; m_pulse = 0; m_recov = 0;
            m_data = 8'hFF; m_dout = 8'h00; m_oe = 1'b0; m_weprev = 1'b1;
            for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
        end else begin
            bit fall, rise, busy;
            int idx, ri;
            logic n_oe;
            logic [7:0] n_dout;
            fall = !ce_n && m_weprev && !we_n;
            rise = !ce_n && !m_weprev && we_n;
            busy = (m_mode == M_PROG) || (m_mode == M_ERASE);
            idx  = int'(addr);
            ri   = (m_mode == M_PCHK || m_mode == M_ECHK) ? m_addr : idx;
            n_oe   = !ce_n && !oe_n && we_n && !busy && (m_recov == 0);
            n_dout = m_mem[ri];
            if (m_recov > 0) m_recov--;
            case (m_mode)
                M_PARM: begin
                    if (fall) m_addr = idx;
                    if (rise) begin
                        if (vpp_hi) begin m_data = din; m_mode = M_PROG; m_pulse = NPROG; end
                        else m_mode = M_READ;
                    end
                end
                M_EARM: begin
                    if (rise) begin
                        if (vpp_hi && din == 8'h20) begin m_mode = M_ERASE; m_pulse = NERA; end
                        else m_mode = M_READ;
                    end
                end
                M_PROG, M_ERASE: begin
                    if (rise || m_pulse == 1) begin
                        if (m_mode == M_PROG) m_mem[m_addr] = m_mem[m_addr] & m_data;
                        else for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'hFF;
                        m_recov = NREC; m_pulse = 0; m_mode = M_READ;
                        if (rise && vpp_hi) m_cmd(idx);
                    end else begin
                        m_pulse--;
                    end
                end
                default: begin
                    if (rise) begin
                        if (vpp_hi) m_cmd(idx);
                        else m_mode = M_READ;
                    end
                end
            endcase
            m_weprev = we_n;
            m_oe     = n_oe;
            m_dout   = n_dout;
        end
    end

    // Compare on every falling edge, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R2 model flag", dout_oe, m_oe);
            if (m_oe) chk("R2 model byte", dout, m_dout);
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [AW-1:0] a_fall, input logic [AW-1:0] a_rise, input logic [7:0] d);
        @(negedge clk); ce_n = 1'b0; addr = a_fall; din = d; we_n = 1'b0;
        @(negedge clk); we_n = 1'b1; addr = a_rise;
        @(negedge clk); ce_n = 1'b1;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [7:0] v, output logic f);
        @(negedge clk); addr = a; ce_n = 1'b0; oe_n = 1'b0;
        @(negedge clk);
        @(negedge clk); v = dout; f = dout_oe;
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    // Called right after wr(); counts falling edges until the flag rises.
    task automatic wait_oe(output int n);
        ce_n = 1'b0; oe_n = 1'b0; n = 0;
        do begin
            @(negedge clk); n++;
        end while (!dout_oe && n < 200);
        oe_n = 1'b1; ce_n = 1'b1;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int cnt;
        logic [7:0] v;
        logic f;
        bit all_ff;

        repeat (3) @(negedge clk);
        chk("R1 flag low in reset", dout_oe, 1'b0);
        rst_n = 1'b1;
        idle(2);
        chk("R1 flag low after reset", dout_oe, 1'b0);
        rd(5'd7, v, f);
        chk("R1 erased after reset", v, 8'hFF);
        chk("R2 flag with strobes", f, 1'b1);

        // R3: address from falling edge, data from rising edge
        wr(5'd0, 5'd0, 8'h40);
        wr(5'd3, 5'd9, 8'h5A);
        wait_oe(cnt);
        chk("R4 pulse plus R9 recovery length", cnt, NPROG + NREC + 1);
        rd(5'd3, v, f);
        chk("R3 programmed byte", v, 8'h5A);
        rd(5'd9, v, f);
        chk("R3 rising-edge address untouched", v, 8'hFF);

        // R3/R6: reprogram clears bits only, then verify at latched address
        wr(5'd0, 5'd0, 8'h40);
        wr(5'd3, 5'd3, 8'h0F);
        idle(NPROG + NREC + 2);
        wr(5'd20, 5'd20, 8'hC0);
        rd(5'd17, v, f);
        chk("R6 verify reads latched address", v, 8'h0A);
        chk("R3 AND of old and new", v, 8'h0A);

        // R5/R12: C0 write during a pulse ends it; its falling edge keeps the address
        wr(5'd0, 5'd0, 8'h40);
        wr(5'd4, 5'd4, 8'hF0);
        wr(5'd11, 5'd11, 8'hC0);
        wait_oe(cnt);
        chk("R5 early end leaves only recovery", cnt, NREC + 1);
        rd(5'd0, v, f);
        chk("R12 latched address kept", v, 8'hF0);

        // R11: unknown command returns to read mode
        wr(5'd0, 5'd0, 8'h55);
        rd(5'd3, v, f);
        chk("R11 unknown command gives read mode", v, 8'h0A);

        // R10: without high voltage nothing is programmed
        vpp_hi = 1'b0;
        wr(5'd0, 5'd0, 8'h40);
        wr(5'd5, 5'd5, 8'h00);
        wait_oe(cnt);
        chk("R10 no pulse without voltage", cnt, 1);
        rd(5'd5, v, f);
        chk("R10 byte unchanged", v, 8'hFF);
        wr(5'd0, 5'd0, 8'h20);
        wr(5'd0, 5'd0, 8'h20);
        rd(5'd3, v, f);
        chk("R10 erase refused", v, 8'h0A);
        vpp_hi = 1'b1;

        // R8: erase-verify address from A0 write's rising edge
        wr(5'd0, 5'd0, 8'h40);
        wr(5'd6, 5'd6, 8'h3C);
        idle(NPROG + NREC + 2);
        wr(5'd1, 5'd6, 8'hA0);
        rd(5'd0, v, f);
        chk("R8 erase-verify address", v, 8'h3C);

        // R11: aborted erase arming
        wr(5'd0, 5'd0, 8'h20);
        wr(5'd0, 5'd0, 8'h33);
        rd(5'd6, v, f);
        chk("R11 aborted erase keeps data", v, 8'h3C);

        // R7/R9: full erase
        wr(5'd0, 5'd0, 8'h20);
        wr(5'd0, 5'd0, 8'h20);
        wait_oe(cnt);
        chk("R7 erase pulse plus R9 recovery", cnt, NERA + NREC + 1);
        all_ff = 1'b1;
        for (int i = 0; i < DEPTH; i++) begin
            rd(AW'(i), v, f);
            if (v !== 8'hFF || f !== 1'b1) all_ff = 1'b0;
        end
        chk("R7 every byte erased", all_ff, 1'b1);

        idle(4);
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

endmodule